// File: doc/BRIEF.md
# Interrupt Return and Privilege Controller

This block keeps the control state behind a small core's interrupt system: the saved return address, a vector of in-service interrupt levels, a global interrupt-disable flag, a kernel/user mode flag and a switch that turns privilege checking on. When an interrupt is taken it records the address of the next instruction, marks that level as in service, masks further interrupts, forces kernel mode and sends the core to the level's vector. It carries out four commands from the decoder: return from interrupt, enable interrupts, disable interrupts, and a write to one of its own mapped registers.

Return from interrupt never asks whether a service routine is actually running. It always jumps to whatever return address is stored, clears the interrupt-disable flag and retires the highest-priority in-service level if there is one. When privilege checking is on, it also drops the core into user mode. In user mode, with checking on, all four commands are refused: no state changes, and a one-cycle fault pulse is raised instead. Nothing else is saved in hardware. Software is expected to save any other context.

Top module: `irc_ctrl`

## Requirements
- R1: After reset, the return address and in-service vector are zero, interrupts are disabled (status bit 1 = 1), the mode is kernel (status bit 2 = 1), privilege checking is off (status bit 3 = 0), status bit 0 (any level in service) is 0, and neither redirect nor fault is asserted.
- R2: An interrupt is taken when no command is presented, status bit 1 is 0, and the lowest-index requesting line has a lower index than the lowest in-service bit (or nothing is in service). Index 0 is the most urgent. On the next clock edge, redirect_valid pulses with redirect_pc = VEC_BASE + index*VEC_STRIDE.
- R3: When an interrupt is taken, the stored return address becomes pc_next, the chosen in-service bit is set, status bit 1 is set to 1 and status bit 2 is set to 1 (kernel), all on the same edge.
- R4: A permitted return (cmd_op = 0) pulses redirect_valid on the next edge with redirect_pc equal to the return address held before that edge, and it clears status bit 1. This applies whether or not any level is in service.
- R5: A permitted return clears only the lowest-index set in-service bit. With nothing in service, the in-service vector stays zero.
- R6: A permitted return sets status bit 2 to 0 (user) only when privilege checking is on. Otherwise the mode is left unchanged.
- R7: A permitted enable command (cmd_op = 1) clears status bit 1, and a permitted disable command (cmd_op = 2) sets it, each on the next edge.
- R8: With privilege checking on and status bit 2 = 0, every command is refused. The return address, in-service vector and status do not change, no redirect occurs, and fault pulses on the next edge.
- R9: A permitted register write (cmd_op = 3) updates one register, chosen by mmr_sel. Select 0 loads the return address from mmr_wdata. Select 1 sets privilege checking from mmr_wdata bit CFG_BIT (25). Select 2 loads status bit 1 from mmr_wdata bit 1 and status bit 2 from mmr_wdata bit 2. Select 3 loads the in-service vector from the low bits of mmr_wdata.
- R10: When a command is presented in the same cycle as a qualifying request, only the command acts. The interrupt is not taken in that cycle.
- R11: redirect_valid and fault last one cycle for each event and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NIRQ | Interrupt request lines, index 0 most urgent |
| pc_next | input | AW | Address of the next instruction to execute |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 2 | 0 return, 1 enable, 2 disable, 3 register write |
| mmr_sel | input | 2 | Register chosen by a register write |
| mmr_wdata | input | DW | Register write data |
| redirect_valid | output | 1 | One-cycle program-counter redirect |
| redirect_pc | output | AW | Redirect target |
| fault | output | 1 | One-cycle refused-command pulse |
| status_o | output | 4 | {checking on, kernel, interrupts disabled, any in service} |
| ipend_o | output | NIRQ | In-service vector |
| iret_o | output | AW | Stored return address |

## Verification
Every result appears exactly one clock edge after the cycle in which its stimulus is presented. All state and both pulses are registered once and have no further pipeline stage. The bench drives each cycle's inputs on a falling edge and steps its own model at that moment. It then compares every output on the following falling edge, half a period after the register updates. So each comparison sees exactly one edge's worth of change, and a pulse that came late or lasted too long shows up as a mismatch on a neighbouring cycle.

// File: rtl/irc_pkg.sv
package irc_pkg;

  typedef enum logic [1:0] {
    OP_RETI = 2'd0,
    OP_IEN  = 2'd1,
    OP_IDIS = 2'd2,
    OP_WREG = 2'd3
  } irc_op_e;

  typedef enum logic [1:0] {
    REG_RET  = 2'd0,
    REG_CFG  = 2'd1,
    REG_STAT = 2'd2,
    REG_SERV = 2'd3
  } irc_reg_e;

  localparam int unsigned ST_BUSY = 0;
  localparam int unsigned ST_DIS  = 1;
  localparam int unsigned ST_KERN = 2;
  localparam int unsigned ST_CHK  = 3;
  localparam int unsigned ST_W    = 4;

endpackage

// File: rtl/irc_prio_pick.sv
module irc_prio_pick #(
  parameter int unsigned N = 10,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec_i,
  output logic [N-1:0]  first_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);

  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_chain
    assign first_o[g]  = vec_i[g] & ~seen[g];
    assign seen[g+1]   = seen[g] | vec_i[g];
  end

  assign any_o = seen[N];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      idx_o = idx_o | (first_o[i] ? IW'(i) : '0);
    end
  end

endmodule

// File: rtl/irc_priv_gate.sv
module irc_priv_gate
  import irc_pkg::*;
(
  input  logic    cmd_valid,
  input  irc_op_e op,
  input  logic    chk_en,
  input  logic    kern,
  output logic    go_reti,
  output logic    go_ien,
  output logic    go_idis,
  output logic    go_wreg,
  output logic    refused
);

  logic allowed;

  assign refused = cmd_valid & chk_en & ~kern;
  assign allowed = cmd_valid & ~refused;

  assign go_reti = allowed & (op == OP_RETI);
  assign go_ien  = allowed & (op == OP_IEN);
  assign go_idis = allowed & (op == OP_IDIS);
  assign go_wreg = allowed & (op == OP_WREG);

endmodule

// File: rtl/irc_state.sv
module irc_state
  import irc_pkg::*;
#(
  parameter int unsigned NIRQ    = 10,
  parameter int unsigned AW      = 32,
  parameter int unsigned DW      = 32,
  parameter int unsigned CFG_BIT = 25
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_irq,
  input  logic [NIRQ-1:0] irq_first,
  input  logic [AW-1:0]   pc_next,
  input  logic            go_reti,
  input  logic            go_ien,
  input  logic            go_idis,
  input  logic            go_wreg,
  input  irc_reg_e        wsel,
  input  logic [DW-1:0]   wdata,
  input  logic [NIRQ-1:0] serv_first,
  output logic [AW-1:0]   ret_q,
  output logic [NIRQ-1:0] serv_q,
  output logic            dis_q,
  output logic            kern_q,
  output logic            chk_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ret_q  <= '0;
      serv_q <= '0;
      dis_q  <= 1'b1;
      kern_q <= 1'b1;
      chk_q  <= 1'b0;
    end else if (take_irq) begin
      ret_q  <= pc_next;
      serv_q <= serv_q | irq_first;
      dis_q  <= 1'b1;
      kern_q <= 1'b1;
    end else if (go_reti) begin
      serv_q <= serv_q & ~serv_first;
      dis_q  <= 1'b0;
      if (chk_q) kern_q <= 1'b0;
    end else if (go_ien) begin
      dis_q <= 1'b0;
    end else if (go_idis) begin
      dis_q <= 1'b1;
    end else if (go_wreg) begin
      unique case (wsel)
        REG_RET:  ret_q  <= wdata[AW-1:0];
        REG_CFG:  chk_q  <= wdata[CFG_BIT];
        REG_STAT: begin
          dis_q  <= wdata[ST_DIS];
          kern_q <= wdata[ST_KERN];
        end
        REG_SERV: serv_q <= wdata[NIRQ-1:0];
        default: ;
      endcase
    end
  end

  // R3: entry captures return address and forces masked kernel state
  a_r3_entry_state: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> (ret_q == $past(pc_next)) && dis_q && kern_q
                 && ((serv_q & $past(irq_first)) != '0));

  // R5: a return retires exactly the most urgent in-service level
  a_r5_retire_one: assert property (@(posedge clk) disable iff (!rst_n)
    go_reti |=> serv_q == ($past(serv_q) & ($past(serv_q) - 1'b1)));

  // R6: mode drops to user only when checking is on
  a_r6_user_drop: assert property (@(posedge clk) disable iff (!rst_n)
    go_reti |=> (kern_q == ($past(kern_q) & ~$past(chk_q))));

  // R7: enable and disable commands land on the next edge
  a_r7_ien: assert property (@(posedge clk) disable iff (!rst_n)
    go_ien |=> !dis_q);
  a_r7_idis: assert property (@(posedge clk) disable iff (!rst_n)
    go_idis |=> dis_q);

endmodule

// File: rtl/irc_ctrl.sv
module irc_ctrl
  import irc_pkg::*;
#(
  parameter int unsigned NIRQ       = 10,
  parameter int unsigned AW         = 32,
  parameter int unsigned DW         = 32,
  parameter int unsigned CFG_BIT    = 25,
  parameter logic [31:0] VEC_BASE   = 32'h0000_0100,
  parameter int unsigned VEC_STRIDE = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] irq_req,
  input  logic [AW-1:0]   pc_next,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [1:0]      mmr_sel,
  input  logic [DW-1:0]   mmr_wdata,
  output logic            redirect_valid,
  output logic [AW-1:0]   redirect_pc,
  output logic            fault,
  output logic [3:0]      status_o,
  output logic [NIRQ-1:0] ipend_o,
  output logic [AW-1:0]   iret_o
);

  localparam int unsigned IW = (NIRQ > 1) ? $clog2(NIRQ) : 1;

  function automatic logic [AW-1:0] vec_addr(input logic [IW-1:0] idx);
    return AW'(VEC_BASE) + AW'(idx) * AW'(VEC_STRIDE);
  endfunction

  function automatic logic outranks(input logic [IW-1:0] req_idx,
                                    input logic          cur_any,
                                    input logic [IW-1:0] cur_idx);
    return !cur_any || (req_idx < cur_idx);
  endfunction

  // internal events, named for the assertions
  logic [NIRQ-1:0] irq_first, serv_first;
  logic [IW-1:0]   irq_idx, serv_idx;
  logic            irq_any, serv_any;
  logic            take_irq;
  logic            go_reti, go_ien, go_idis, go_wreg, refused;
  logic [AW-1:0]   ret_q;
  logic [NIRQ-1:0] serv_q;
  logic            dis_q, kern_q, chk_q;

  irc_prio_pick #(.N(NIRQ)) u_req_pick (
    .vec_i(irq_req), .first_o(irq_first), .idx_o(irq_idx), .any_o(irq_any)
  );

  irc_prio_pick #(.N(NIRQ)) u_serv_pick (
    .vec_i(serv_q), .first_o(serv_first), .idx_o(serv_idx), .any_o(serv_any)
  );

  irc_priv_gate u_gate (
    .cmd_valid(cmd_valid),
    .op       (irc_op_e'(cmd_op)),
    .chk_en   (chk_q),
    .kern     (kern_q),
    .go_reti  (go_reti),
    .go_ien   (go_ien),
    .go_idis  (go_idis),
    .go_wreg  (go_wreg),
    .refused  (refused)
  );

  assign take_irq = !cmd_valid && !dis_q && irq_any
                    && outranks(irq_idx, serv_any, serv_idx);

  irc_state #(.NIRQ(NIRQ), .AW(AW), .DW(DW), .CFG_BIT(CFG_BIT)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_irq  (take_irq),
    .irq_first (irq_first),
    .pc_next   (pc_next),
    .go_reti   (go_reti),
    .go_ien    (go_ien),
    .go_idis   (go_idis),
    .go_wreg   (go_wreg),
    .wsel      (irc_reg_e'(mmr_sel)),
    .wdata     (mmr_wdata),
    .serv_first(serv_first),
    .ret_q     (ret_q),
    .serv_q    (serv_q),
    .dis_q     (dis_q),
    .kern_q    (kern_q),
    .chk_q     (chk_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      fault          <= 1'b0;
    end else begin
      redirect_valid <= take_irq | go_reti;
      fault          <= refused;
      if (take_irq)     redirect_pc <= vec_addr(irq_idx);
      else if (go_reti) redirect_pc <= ret_q;
    end
  end

  always_comb begin
    status_o           = '0;
    status_o[ST_BUSY]  = |serv_q;
    status_o[ST_DIS]   = dis_q;
    status_o[ST_KERN]  = kern_q;
    status_o[ST_CHK]   = chk_q;
  end

  assign ipend_o = serv_q;
  assign iret_o  = ret_q;

  // R2: a taken interrupt redirects to its vector on the next edge
  a_r2_vector: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> redirect_valid
                 && redirect_pc == AW'(VEC_BASE) + AW'($past(irq_idx)) * AW'(VEC_STRIDE));

  // R4: return goes to the address stored before the edge
  a_r4_return_target: assert property (@(posedge clk) disable iff (!rst_n)
    go_reti |=> redirect_valid && redirect_pc == $past(ret_q) && !status_o[ST_DIS]);

  // R8: refused command leaves state alone and faults
  a_r8_refused_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    refused |=> fault && !redirect_valid && $stable(iret_o)
                && $stable(ipend_o) && $stable(status_o));

  // R10: no interrupt entry while a command is presented
  a_r10_cmd_first: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !take_irq);

  // R11: redirect and fault never coincide
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(redirect_valid && fault));

endmodule

// File: tb/irc_ctrl_tb.sv
module irc_ctrl_tb;

  localparam int unsigned NIRQ = 10;
  localparam int unsigned AW = 32;
  localparam int unsigned DW = 32;
  localparam int unsigned CFG_BIT = 25;
  localparam logic [31:0] VEC_BASE = 32'h0000_0100;
  localparam int unsigned VEC_STRIDE = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic [NIRQ-1:0] irq_req;
  logic [AW-1:0] pc_next;
  logic cmd_valid;
  logic [1:0] cmd_op, mmr_sel;
  logic [DW-1:0] mmr_wdata;
  logic redirect_valid, fault;
  logic [AW-1:0] redirect_pc, iret_o;
  logic [3:0] status_o;
  logic [NIRQ-1:0] ipend_o;

  irc_ctrl #(.NIRQ(NIRQ), .AW(AW), .DW(DW), .CFG_BIT(CFG_BIT),
             .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .pc_next(pc_next),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .mmr_sel(mmr_sel),
    .mmr_wdata(mmr_wdata), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .fault(fault), .status_o(status_o),
    .ipend_o(ipend_o), .iret_o(iret_o)
  );

  // bench model
  logic [AW-1:0] m_ret;
  logic [NIRQ-1:0] m_serv;
  logic m_dis, m_kern, m_chk, m_rv, m_fault;
  logic [AW-1:0] m_rpc;
  string m_tag;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  function automatic int most_urgent(input logic [NIRQ-1:0] v);
    int r = -1;
    for (int i = NIRQ - 1; i >= 0; i--) if (v[i]) r = i;
    return r;
  endfunction

  function automatic logic [AW-1:0] vector_of(input int idx);
    return VEC_BASE + AW'(idx * VEC_STRIDE);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(iret_o == m_ret, tag, "iret", iret_o, m_ret);
    chk(ipend_o == m_serv, tag, "ipend", 32'(ipend_o), 32'(m_serv));
    chk(status_o == {m_chk, m_kern, m_dis, |m_serv}, tag, "status",
        32'(status_o), 32'({m_chk, m_kern, m_dis, |m_serv}));
    chk(redirect_valid == m_rv, tag, "redirect_valid", 32'(redirect_valid), 32'(m_rv));
    chk(fault == m_fault, tag, "fault", 32'(fault), 32'(m_fault));
    chk(!(redirect_valid && fault), "R11", "pulse overlap", 32'({redirect_valid, fault}), 32'h0);
    if (m_rv) chk(redirect_pc == m_rpc, tag, "redirect_pc", redirect_pc, m_rpc);
  endtask

  // drive one cycle (caller sits at a falling edge), step the model, compare next falling edge
  task automatic step(input bit cv, input logic [1:0] op, input logic [1:0] sel,
                      input logic [DW-1:0] d, input logic [NIRQ-1:0] irq,
                      input logic [AW-1:0] pc);
    int ri, ci;
    cmd_valid = cv; cmd_op = op; mmr_sel = sel; mmr_wdata = d;
    irq_req = irq; pc_next = pc;
    m_rv = 1'b0; m_fault = 1'b0; m_tag = "R11";
    if (cv) begin
      if (m_chk && !m_kern) begin
        m_fault = 1'b1; m_tag = "R8";
      end else begin
        case (op)
          2'd0: begin
            m_rv = 1'b1; m_rpc = m_ret; m_dis = 1'b0;
            ci = most_urgent(m_serv);
            if (ci >= 0) m_serv[ci] = 1'b0;
            if (m_chk) m_kern = 1'b0;
            m_tag = (ci < 0) ? "R4" : (m_chk ? "R6" : "R5");
          end
          2'd1: begin m_dis = 1'b0; m_tag = "R7"; end
          2'd2: begin m_dis = 1'b1; m_tag = "R7"; end
          default: begin
            m_tag = "R9";
            case (sel)
              2'd0: m_ret = d;
              2'd1: m_chk = d[CFG_BIT];
              2'd2: begin m_dis = d[1]; m_kern = d[2]; end
              default: m_serv = d[NIRQ-1:0];
            endcase
          end
        endcase
      end
      if (irq != '0 && m_tag == "R7") m_tag = "R10";
    end else if (!m_dis) begin
      ri = most_urgent(irq);
      ci = most_urgent(m_serv);
      if (ri >= 0 && (ci < 0 || ri < ci)) begin
        m_ret = pc; m_serv[ri] = 1'b1; m_dis = 1'b1; m_kern = 1'b1;
        m_rv = 1'b1; m_rpc = vector_of(ri); m_tag = "R3";
        if (ci >= 0) m_tag = "R2";
      end
    end
    @(negedge clk);
    compare_all(m_tag);
  endtask

  task automatic idle();
    step(1'b0, 2'd0, 2'd0, '0, '0, 32'h0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; mmr_sel = '0;
    mmr_wdata = '0; irq_req = '0; pc_next = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    m_ret = '0; m_serv = '0; m_dis = 1'b1; m_kern = 1'b1; m_chk = 1'b0;
    m_rv = 1'b0; m_fault = 1'b0; m_rpc = '0;
    compare_all("R1");
    // R2: masked after reset, request ignored
    step(1'b0, 2'd0, 2'd0, '0, 10'b00_0000_1000, 32'h1000);
    // R7: unmask
    step(1'b1, 2'd1, 2'd0, '0, '0, 32'h0);
    // R10: command beats a qualifying request
    step(1'b1, 2'd1, 2'd0, '0, 10'b00_0000_1000, 32'h1004);
    // R3: enter level 3
    step(1'b0, 2'd0, 2'd0, '0, 10'b00_0010_1000, 32'h2000);
    // R9: reopen via status write, keep kernel
    step(1'b1, 2'd3, 2'd2, 32'h4, '0, 32'h0);
    // R2: level 5 does not preempt level 3
    step(1'b0, 2'd0, 2'd0, '0, 10'b00_0010_0000, 32'h2100);
    // R2: level 3 again does not preempt itself
    step(1'b0, 2'd0, 2'd0, '0, 10'b00_0000_1000, 32'h2104);
    // R2: level 1 preempts
    step(1'b0, 2'd0, 2'd0, '0, 10'b00_0000_0010, 32'h3000);
    // R5: two returns retire 1 then 3
    step(1'b1, 2'd0, 2'd0, '0, '0, 32'h0);
    step(1'b1, 2'd2, 2'd0, '0, '0, 32'h0);
    step(1'b1, 2'd0, 2'd0, '0, '0, 32'h0);
    // R4: return with nothing in service jumps to stale address
    step(1'b1, 2'd0, 2'd0, '0, '0, 32'h0);
    // R9: set return address and checking bit
    step(1'b1, 2'd3, 2'd0, 32'hCAFE_0040, '0, 32'h0);
    step(1'b1, 2'd3, 2'd1, 32'h0200_0000, '0, 32'h0);
    // R6: return drops to user
    step(1'b1, 2'd0, 2'd0, '0, '0, 32'h0);
    // R8: every command refused in user mode
    for (int k = 0; k < 4; k++) step(1'b1, 2'(k), 2'd2, 32'h6, '0, 32'h0);
    idle();
    // R3: interrupt returns to kernel
    step(1'b0, 2'd0, 2'd0, '0, 10'b10_0000_0000, 32'h4400);
    // R9: pending vector write, checking off
    step(1'b1, 2'd3, 2'd3, 32'h0000_0300, '0, 32'h0);
    step(1'b1, 2'd3, 2'd1, 32'h0, '0, 32'h0);
    // R6: with checking off the mode stays kernel
    step(1'b1, 2'd0, 2'd0, '0, '0, 32'h0);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      bit cv;
      logic [1:0] op, sel;
      logic [DW-1:0] d;
      logic [NIRQ-1:0] irq;
      cv  = ($urandom % 4) == 0;
      op  = 2'($urandom);
      sel = 2'($urandom);
      d   = $urandom;
      if (sel == 2'd1) d[CFG_BIT] = ($urandom % 3) != 0;
      if (sel == 2'd3) d = d & 32'h0000_0155;
      irq = ($urandom % 3 == 0) ? NIRQ'(1 << ($urandom % NIRQ)) : '0;
      if ($urandom % 8 == 0) irq = irq | NIRQ'($urandom);
      step(cv, op, sel, d, irq, $urandom);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule